// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control sequencer for a processor datapath that runs one instruction over several clock cycles. It shares one memory port and one ALU across those cycles. It looks at the 6-bit opcode held in the instruction register and walks a state machine through fetch, decode and a class-specific tail of states. In every state it drives the datapath steering and write-enable pins.

Every output is a pure function of the current state, so the datapath sees stable controls for the whole cycle. The opcode is consulted only when the machine leaves the decode state. Each instruction class therefore takes its own number of cycles, and every path ends back in fetch. The block has no data stream of its own. Clock, reset, the opcode and all control pins are plain level signals.

Top module: `mc_sequencer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the machine in the fetch state. The fetch control word is on the outputs in the cycle after that edge.
- R2: In fetch the outputs are `mem_rd`=1, `ir_we`=1, `pc_we`=1, `alu_b_sel`=01 (constant four), `alu_a_sel`=0 (PC), `alu_mode`=00 (add), `addr_sel_data`=0 and `pc_next_sel`=00. Every output not named for a state in R2 to R8 is 0 in that state.
- R3: Decode follows fetch in every case. Its outputs are `alu_a_sel`=0, `alu_b_sel`=11 (shifted immediate) and `alu_mode`=00, which precompute the branch target.
- R4: A load (opcode 100011) takes 5 cycles. After decode come three states. The address state has `alu_a_sel`=1, `alu_b_sel`=10 and `alu_mode`=00. The memory state has `mem_rd`=1 and `addr_sel_data`=1. The write-back state has `rf_we`=1, `wb_sel_mem`=1 and `rf_dst_rd`=0.
- R5: A store (opcode 101011) takes 4 cycles: the same address state as R4, then one memory state with `mem_wr`=1 and `addr_sel_data`=1.
- R6: A register-register operation (opcode 000000) takes 4 cycles. The execute state has `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=10 (function-field decode). The completion state has `rf_we`=1, `rf_dst_rd`=1 and `wb_sel_mem`=0.
- R7: A branch-if-equal (opcode 000100) takes 3 cycles. Its one state has `pc_we_if_eq`=1, `pc_next_sel`=01, `alu_a_sel`=1, `alu_b_sel`=00 and `alu_mode`=01 (subtract).
- R8: A jump (opcode 000010) takes 3 cycles. Its one state has `pc_we`=1 and `pc_next_sel`=10.
- R9: Any other opcode goes from decode straight back to fetch, so it takes 2 cycles.
- R10: The opcode has no effect in any state other than decode. Changing it mid-instruction leaves the rest of the sequence unchanged.
- R11: In no cycle is more than one of `rf_we`, `mem_wr`, `ir_we` and `pc_we_if_eq` high, and `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| pc_we | output | 1 | Unconditional program-counter write |
| pc_we_if_eq | output | 1 | Program-counter write when the ALU reports equal operands |
| addr_sel_data | output | 1 | Memory address from ALU result register (1) or PC (0) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| wb_sel_mem | output | 1 | Register write data from memory data register (1) or ALU result register (0) |
| ir_we | output | 1 | Instruction register load |
| pc_next_sel | output | 2 | Next PC source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_mode | output | 2 | 00 add, 01 subtract, 10 function-field decode |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 register B, 01 four, 10 immediate, 11 shifted immediate |
| rf_we | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination register from rd field (1) or rt field (0) |

## Verification
Fetch does two jobs in one cycle: it reads the instruction from memory and, through the shared ALU, advances the PC. Decode likewise reads registers while the ALU forms the branch target. The bench runs every one of the 64 opcodes back to back, so each fetch directly follows the last state of the previous class. It compares the whole packed control word in every cycle, which shows that the read, the IR load and the PC update are present together and that no write enable leaks in from the state before. A second sweep changes the opcode after decode. A reset is also applied in the middle of a load.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  typedef enum logic [3:0] {
    S_FETCH   = 4'd0,
    S_DECODE  = 4'd1,
    S_ADDR_LD = 4'd2,
    S_ADDR_ST = 4'd3,
    S_LD_MEM  = 4'd4,
    S_LD_WB   = 4'd5,
    S_ST_MEM  = 4'd6,
    S_EXEC    = 4'd7,
    S_ALU_WB  = 4'd8,
    S_BRANCH  = 4'd9,
    S_JUMP    = 4'd10
  } state_e;

  typedef enum logic [2:0] {
    C_ALU    = 3'd0,
    C_LOAD   = 3'd1,
    C_STORE  = 3'd2,
    C_BRANCH = 3'd3,
    C_JUMP   = 3'd4,
    C_OTHER  = 3'd5
  } class_e;

  localparam logic [1:0] ALU_ADD   = 2'b00;
  localparam logic [1:0] ALU_SUB   = 2'b01;
  localparam logic [1:0] ALU_FUNCT = 2'b10;

  localparam logic [1:0] BSEL_REG  = 2'b00;
  localparam logic [1:0] BSEL_FOUR = 2'b01;
  localparam logic [1:0] BSEL_IMM  = 2'b10;
  localparam logic [1:0] BSEL_SIMM = 2'b11;

  localparam logic [1:0] PCSEL_ALU = 2'b00;
  localparam logic [1:0] PCSEL_REG = 2'b01;
  localparam logic [1:0] PCSEL_JMP = 2'b10;

  typedef struct packed {
    logic       pc_we;
    logic       pc_we_if_eq;
    logic       addr_sel_data;
    logic       mem_rd;
    logic       mem_wr;
    logic       wb_sel_mem;
    logic       ir_we;
    logic [1:0] pc_next_sel;
    logic [1:0] alu_mode;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic       rf_we;
    logic       rf_dst_rd;
  } ctrl_t;

endpackage

// File: rtl/mcs_classify.sv
module mcs_classify
  import mcs_pkg::*;
#(
  parameter int                OPC_W     = 6,
  parameter logic [OPC_W-1:0]  OP_ALU    = 6'b000000,
  parameter logic [OPC_W-1:0]  OP_LOAD   = 6'b100011,
  parameter logic [OPC_W-1:0]  OP_STORE  = 6'b101011,
  parameter logic [OPC_W-1:0]  OP_BRANCH = 6'b000100,
  parameter logic [OPC_W-1:0]  OP_JUMP   = 6'b000010
) (
  input  logic [OPC_W-1:0] opcode,
  output class_e           cls
);

  always_comb begin
    if (opcode == OP_ALU)         cls = C_ALU;
    else if (opcode == OP_LOAD)   cls = C_LOAD;
    else if (opcode == OP_STORE)  cls = C_STORE;
    else if (opcode == OP_BRANCH) cls = C_BRANCH;
    else if (opcode == OP_JUMP)   cls = C_JUMP;
    else                          cls = C_OTHER;
  end

endmodule

// File: rtl/mcs_next_state.sv
module mcs_next_state
  import mcs_pkg::*;
(
  input  state_e cur,
  input  class_e cls,
  output state_e nxt
);

  always_comb begin
    nxt = S_FETCH;
    case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        case (cls)
          C_ALU:    nxt = S_EXEC;
          C_LOAD:   nxt = S_ADDR_LD;
          C_STORE:  nxt = S_ADDR_ST;
          C_BRANCH: nxt = S_BRANCH;
          C_JUMP:   nxt = S_JUMP;
          default:  nxt = S_FETCH;
        endcase
      end
      S_ADDR_LD: nxt = S_LD_MEM;
      S_LD_MEM:  nxt = S_LD_WB;
      S_ADDR_ST: nxt = S_ST_MEM;
      S_EXEC:    nxt = S_ALU_WB;
      default:   nxt = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mcs_outputs.sv
module mcs_outputs
  import mcs_pkg::*;
(
  input  state_e cur,
  output ctrl_t  ctl
);

  always_comb begin
    ctl = '0;
    case (cur)
      S_FETCH: begin
        ctl.mem_rd    = 1'b1;
        ctl.ir_we     = 1'b1;
        ctl.pc_we     = 1'b1;
        ctl.alu_b_sel = BSEL_FOUR;
        ctl.alu_mode  = ALU_ADD;
        ctl.pc_next_sel = PCSEL_ALU;
      end
      S_DECODE: begin
        ctl.alu_b_sel = BSEL_SIMM;
        ctl.alu_mode  = ALU_ADD;
      end
      S_ADDR_LD, S_ADDR_ST: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_IMM;
        ctl.alu_mode  = ALU_ADD;
      end
      S_LD_MEM: begin
        ctl.mem_rd        = 1'b1;
        ctl.addr_sel_data = 1'b1;
      end
      S_LD_WB: begin
        ctl.rf_we      = 1'b1;
        ctl.wb_sel_mem = 1'b1;
      end
      S_ST_MEM: begin
        ctl.mem_wr        = 1'b1;
        ctl.addr_sel_data = 1'b1;
      end
      S_EXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_REG;
        ctl.alu_mode  = ALU_FUNCT;
      end
      S_ALU_WB: begin
        ctl.rf_we     = 1'b1;
        ctl.rf_dst_rd = 1'b1;
      end
      S_BRANCH: begin
        ctl.alu_a_sel   = 1'b1;
        ctl.alu_b_sel   = BSEL_REG;
        ctl.alu_mode    = ALU_SUB;
        ctl.pc_we_if_eq = 1'b1;
        ctl.pc_next_sel = PCSEL_REG;
      end
      S_JUMP: begin
        ctl.pc_we       = 1'b1;
        ctl.pc_next_sel = PCSEL_JMP;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mc_sequencer.sv
module mc_sequencer
  import mcs_pkg::*;
#(
  parameter int                OPC_W     = 6,
  parameter logic [OPC_W-1:0]  OP_ALU    = 6'b000000,
  parameter logic [OPC_W-1:0]  OP_LOAD   = 6'b100011,
  parameter logic [OPC_W-1:0]  OP_STORE  = 6'b101011,
  parameter logic [OPC_W-1:0]  OP_BRANCH = 6'b000100,
  parameter logic [OPC_W-1:0]  OP_JUMP   = 6'b000010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic             pc_we,
  output logic             pc_we_if_eq,
  output logic             addr_sel_data,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             wb_sel_mem,
  output logic             ir_we,
  output logic [1:0]       pc_next_sel,
  output logic [1:0]       alu_mode,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic             rf_we,
  output logic             rf_dst_rd
);

  state_e state_q;
  state_e state_d;
  class_e op_cls;
  ctrl_t  ctl;

  mcs_classify #(
    .OPC_W(OPC_W), .OP_ALU(OP_ALU), .OP_LOAD(OP_LOAD),
    .OP_STORE(OP_STORE), .OP_BRANCH(OP_BRANCH), .OP_JUMP(OP_JUMP)
  ) u_classify (
    .opcode(opcode),
    .cls   (op_cls)
  );

  mcs_next_state u_next (
    .cur(state_q),
    .cls(op_cls),
    .nxt(state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_FETCH;
    else     state_q <= state_d;
  end

  mcs_outputs u_outputs (
    .cur(state_q),
    .ctl(ctl)
  );

  assign pc_we         = ctl.pc_we;
  assign pc_we_if_eq   = ctl.pc_we_if_eq;
  assign addr_sel_data = ctl.addr_sel_data;
  assign mem_rd        = ctl.mem_rd;
  assign mem_wr        = ctl.mem_wr;
  assign wb_sel_mem    = ctl.wb_sel_mem;
  assign ir_we         = ctl.ir_we;
  assign pc_next_sel   = ctl.pc_next_sel;
  assign alu_mode      = ctl.alu_mode;
  assign alu_a_sel     = ctl.alu_a_sel;
  assign alu_b_sel     = ctl.alu_b_sel;
  assign rf_we         = ctl.rf_we;
  assign rf_dst_rd     = ctl.rf_dst_rd;

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker (
  input logic       clk,
  input logic       rst,
  input logic       pc_we,
  input logic       pc_we_if_eq,
  input logic       addr_sel_data,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       wb_sel_mem,
  input logic       ir_we,
  input logic [1:0] pc_next_sel,
  input logic [1:0] alu_mode,
  input logic       alu_a_sel,
  input logic [1:0] alu_b_sel,
  input logic       rf_we,
  input logic       rf_dst_rd
);

  // R11: read and write strobes are exclusive
  p_mem_excl_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  // R11: at most one write-type enable
  p_one_write_r11: assert property (@(posedge clk) disable iff (rst)
    $countones({rf_we, mem_wr, ir_we, pc_we_if_eq}) <= 1);

  // R2: instruction load comes with PC advance and a PC-addressed read
  p_fetch_pair_r2: assert property (@(posedge clk) disable iff (rst)
    ir_we |-> (pc_we && mem_rd && !addr_sel_data && alu_b_sel == 2'b01));

  // R3: the cycle after fetch is decode
  p_decode_next_r3: assert property (@(posedge clk) disable iff (rst)
    ir_we |=> (alu_b_sel == 2'b11 && !alu_a_sel && !ir_we));

  // R4: load memory read is followed by write-back from memory data
  p_load_wb_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && addr_sel_data) |=> (rf_we && wb_sel_mem && !rf_dst_rd));

  // R5: store memory write returns to fetch
  p_store_ret_r5: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> ir_we);

  // R6: register write returns to fetch
  p_rf_ret_r6: assert property (@(posedge clk) disable iff (rst)
    rf_we |=> ir_we);

  // R7: conditional PC write uses subtract and the stored target
  p_branch_r7: assert property (@(posedge clk) disable iff (rst)
    pc_we_if_eq |-> (alu_mode == 2'b01 && pc_next_sel == 2'b01 && !pc_we));

  // R8: jump returns to fetch
  p_jump_ret_r8: assert property (@(posedge clk) disable iff (rst)
    (pc_we && pc_next_sel == 2'b10) |=> ir_we);

endmodule

bind mc_sequencer mcs_checker u_mcs_checker (
  .clk(clk), .rst(rst), .pc_we(pc_we), .pc_we_if_eq(pc_we_if_eq),
  .addr_sel_data(addr_sel_data), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .wb_sel_mem(wb_sel_mem), .ir_we(ir_we), .pc_next_sel(pc_next_sel),
  .alu_mode(alu_mode), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
  .rf_we(rf_we), .rf_dst_rd(rf_dst_rd)
);

// File: tb/mc_sequencer_bench.sv
module mc_sequencer_bench;

  localparam time CLK_P = 20ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       pc_we, pc_we_if_eq, addr_sel_data, mem_rd, mem_wr, wb_sel_mem, ir_we;
  logic [1:0] pc_next_sel, alu_mode, alu_b_sel;
  logic       alu_a_sel, rf_we, rf_dst_rd;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mc_sequencer u_mc_sequencer (
    .clk(clk), .rst(rst), .opcode(opcode),
    .pc_we(pc_we), .pc_we_if_eq(pc_we_if_eq), .addr_sel_data(addr_sel_data),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_sel_mem(wb_sel_mem), .ir_we(ir_we),
    .pc_next_sel(pc_next_sel), .alu_mode(alu_mode), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .rf_we(rf_we), .rf_dst_rd(rf_dst_rd)
  );

  // word order: pc_we, pc_we_if_eq, addr_sel_data, mem_rd, mem_wr, wb_sel_mem,
  // ir_we, pc_next_sel[2], alu_mode[2], alu_a_sel, alu_b_sel[2], rf_we, rf_dst_rd
  function automatic logic [15:0] mk(bit pw, bit pwe, bit ad, bit mr, bit mw, bit wm,
                                     bit iw, logic [1:0] ps, logic [1:0] am,
                                     bit aa, logic [1:0] ab, bit rw, bit rd);
    return {pw, pwe, ad, mr, mw, wm, iw, ps, am, aa, ab, rw, rd};
  endfunction

  function automatic logic [15:0] w_fetch();  return mk(1,0,0,1,0,0,1,2'b00,2'b00,0,2'b01,0,0); endfunction
  function automatic logic [15:0] w_decode(); return mk(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b11,0,0); endfunction
  function automatic logic [15:0] w_addr();   return mk(0,0,0,0,0,0,0,2'b00,2'b00,1,2'b10,0,0); endfunction
  function automatic logic [15:0] w_ldmem();  return mk(0,0,1,1,0,0,0,2'b00,2'b00,0,2'b00,0,0); endfunction
  function automatic logic [15:0] w_ldwb();   return mk(0,0,0,0,0,1,0,2'b00,2'b00,0,2'b00,1,0); endfunction
  function automatic logic [15:0] w_stmem();  return mk(0,0,1,0,1,0,0,2'b00,2'b00,0,2'b00,0,0); endfunction
  function automatic logic [15:0] w_exec();   return mk(0,0,0,0,0,0,0,2'b00,2'b10,1,2'b00,0,0); endfunction
  function automatic logic [15:0] w_aluwb();  return mk(0,0,0,0,0,0,0,2'b00,2'b00,0,2'b00,1,1); endfunction
  function automatic logic [15:0] w_branch(); return mk(0,1,0,0,0,0,0,2'b01,2'b01,1,2'b00,0,0); endfunction
  function automatic logic [15:0] w_jump();   return mk(1,0,0,0,0,0,0,2'b10,2'b00,0,2'b00,0,0); endfunction

  // number of states after decode, from the cycle counts
  function automatic int tail_len(logic [5:0] o);
    if (o == 6'b100011) return 3;
    if (o == 6'b101011) return 2;
    if (o == 6'b000000) return 2;
    if (o == 6'b000100) return 1;
    if (o == 6'b000010) return 1;
    return 0;
  endfunction

  function automatic string tail_req(logic [5:0] o);
    if (o == 6'b100011) return "R4";
    if (o == 6'b101011) return "R5";
    if (o == 6'b000000) return "R6";
    if (o == 6'b000100) return "R7";
    if (o == 6'b000010) return "R8";
    return "R9";
  endfunction

  function automatic logic [15:0] tail_word(logic [5:0] o, int k);
    if (o == 6'b100011) return (k == 0) ? w_addr() : (k == 1) ? w_ldmem() : w_ldwb();
    if (o == 6'b101011) return (k == 0) ? w_addr() : w_stmem();
    if (o == 6'b000000) return (k == 0) ? w_exec() : w_aluwb();
    if (o == 6'b000100) return w_branch();
    return w_jump();
  endfunction

  function automatic logic [15:0] got();
    return {pc_we, pc_we_if_eq, addr_sel_data, mem_rd, mem_wr, wb_sel_mem, ir_we,
            pc_next_sel, alu_mode, alu_a_sel, alu_b_sel, rf_we, rf_dst_rd};
  endfunction

  task automatic chk(string req, logic [15:0] exp);
    logic [15:0] g;
    g = got();
    checks++;
    if (g !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h at %0t", req, g, exp, $time);
    end
    checks++;
    if ($countones({rf_we, mem_wr, ir_we, pc_we_if_eq}) > 1 || (mem_rd && mem_wr)) begin
      errors++;
      $display("FAIL R11 got %h exp at most one write enable", g);
    end
  endtask

  // called at a negedge while in fetch; returns at the negedge of the next fetch
  task automatic run_instr(logic [5:0] o, bit scramble);
    int n;
    chk("R2", w_fetch());
    opcode = o;
    @(negedge clk);
    chk("R3", w_decode());
    n = tail_len(o);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(scramble && k > 0 ? "R10" : tail_req(o), tail_word(o, k));
      if (scramble && k == 0) opcode = ~o;
    end
    @(negedge clk);
    if (n == 0) chk("R9", w_fetch());
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", w_fetch());
    rst = 1'b0;
    for (int pass = 0; pass < 2; pass++)
      for (int o = 0; o < 64; o++)
        run_instr(6'(o), pass == 1);
    // reset in the middle of a load: R1
    chk("R2", w_fetch());
    opcode = 6'b100011;
    @(negedge clk);
    chk("R3", w_decode());
    @(negedge clk);
    chk("R4", w_addr());
    rst = 1'b1;
    @(negedge clk);
    chk("R1", w_fetch());
    rst = 1'b0;
    run_instr(6'b000010, 1'b0);
    run_instr(6'b000000, 1'b0);
    chk("R2", w_fetch());
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule